// File: doc/BRIEF.md
# Dual-Pipe Instruction Pairing Steering

This block sits between a two-wide decode stage and a pair of integer pipes named X and Y. Each cycle, decode offers up to two instructions in program order: an older candidate and a younger one. Each candidate carries a two-bit class code and an opaque payload. From the two classes, an external pairing-hazard input, and the ready signals of both pipes, the block works out the cycle's issue decision. It issues the older instruction alone, issues both as a pair, or issues nothing. It routes each issued instruction to a pipe slot and acknowledges the candidates it consumed.

Branch and floating-point instructions may only occupy X, but they can still run beside a partner in Y. Exclusive instructions always issue with Y empty. When the younger candidate cannot pair, only the older one is taken. Decode must then present the younger one as the older candidate on the next cycle, so the pipes see instructions in program order. The block is purely combinational on its data path. The clock and reset serve only the embedded checking properties.

A build-time option, `SWAP_EN`, allows one extra pairing when there is no hazard: a simple older instruction followed by an X-only younger one. In that case the younger goes to X and the older to Y. A one-bit output marks that the older instruction sits in Y, so that later ordering logic can restore program order.

Top module: `steer_dual_issue`

## Requirements
- R1: At most one instruction is issued into X and at most one into Y each cycle. Y is never valid without X. The class and payload outputs of an idle slot read zero. The younger candidate is taken only if the older one is also taken, and the number of candidates taken equals the number of slots issued.
- R2: Class codes are 0 simple, 1 branch, 2 floating point and 3 exclusive. A class 1 or class 2 instruction never appears on the Y slot.
- R3: When the older candidate is class 1 or 2, the younger is class 0 and the hazard input is low, both issue: older to X, younger to Y.
- R4: When the older candidate is class 3, it issues alone into X and the younger one is not taken.
- R5: With `SWAP_EN`=0, a class 1 or 2 younger candidate is not taken. The older one alone issues into X.
- R6: A class 3 younger candidate is never paired. Only the older candidate issues, into X.
- R7: While `pair_hazard` is high, Y stays idle and only the older candidate issues, into X.
- R8: If `xp_ready` or `yp_ready` is low, neither slot is valid and neither candidate is taken.
- R9: `yp_holds_older` is 1 exactly when the Y slot holds the older candidate. Otherwise it is 0, and with `SWAP_EN`=0 it is always 0.
- R10: With `SWAP_EN`=1, a class 0 older candidate paired with a class 1 or 2 younger candidate, with no hazard, issues the younger to X and the older to Y, sets `yp_holds_older`, and takes both.
- R11: A younger valid with no older valid issues nothing and takes nothing.
- R12: The payload and class of each issued instruction appear unchanged on the slot it was routed to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the checking properties |
| rst_n | input | 1 | Active-low reset for the checking properties |
| dec_valid_old | input | 1 | Older candidate present |
| dec_cls_old | input | 2 | Older candidate class |
| dec_data_old | input | DATA_W | Older candidate payload |
| dec_valid_yng | input | 1 | Younger candidate present |
| dec_cls_yng | input | 2 | Younger candidate class |
| dec_data_yng | input | DATA_W | Younger candidate payload |
| pair_hazard | input | 1 | External dependency hazard, forbids pairing |
| dec_take_old | output | 1 | Older candidate consumed this cycle |
| dec_take_yng | output | 1 | Younger candidate consumed this cycle |
| xp_valid | output | 1 | X slot carries an instruction |
| xp_cls | output | 2 | Class on X slot |
| xp_data | output | DATA_W | Payload on X slot |
| xp_ready | input | 1 | X pipe can accept |
| yp_valid | output | 1 | Y slot carries an instruction |
| yp_cls | output | 2 | Class on Y slot |
| yp_data | output | DATA_W | Payload on Y slot |
| yp_ready | input | 1 | Y pipe can accept |
| yp_holds_older | output | 1 | Y slot holds the older instruction |

## Verification
On every cycle the properties check the slot invariants: Y never issues without X, no X-only class reaches Y, exclusive instructions issue with Y idle, Y stays idle while the hazard is high, the outputs stay quiet during a stall, and the take count agrees with the issued slot count. Only the bench's scenarios can show which instruction lands in which slot and whether a legal pair was actually formed rather than needlessly split. They also show payload integrity and the setting of the order bit under the swap option. The bench covers these by sweeping every combination of valids, classes, hazard and readies for both settings of the swap option.

// File: rtl/steer_pkg.sv
package steer_pkg;

  typedef enum logic [1:0] {
    CLS_SIMPLE = 2'd0,
    CLS_BRANCH = 2'd1,
    CLS_FLOAT  = 2'd2,
    CLS_SOLO   = 2'd3
  } icls_e;

  typedef enum logic [1:0] {
    PLAN_NONE   = 2'd0,
    PLAN_SINGLE = 2'd1,
    PLAN_PAIR   = 2'd2,
    PLAN_SWAP   = 2'd3
  } plan_e;

  // Classes that the Y pipe cannot execute.
  function automatic logic cls_x_only(input logic [1:0] c);
    return (c == CLS_BRANCH) || (c == CLS_FLOAT);
  endfunction

  // Classes that must occupy both pipes alone.
  function automatic logic cls_solo(input logic [1:0] c);
    return c == CLS_SOLO;
  endfunction

  // Slots filled by a plan.
  function automatic logic [1:0] plan_slots(input plan_e p);
    case (p)
      PLAN_NONE:   return 2'd0;
      PLAN_SINGLE: return 2'd1;
      default:     return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/steer_pair_rule.sv
module steer_pair_rule
  import steer_pkg::*;
#(
  parameter bit SWAP_EN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       old_vld,
  input  logic [1:0] old_cls,
  input  logic       yng_vld,
  input  logic [1:0] yng_cls,
  input  logic       hazard,
  input  logic       go,
  output plan_e      plan
);

  // Named internal events, visible to the properties below.
  logic issue_any;
  logic pair_window;
  logic pair_plain;
  logic pair_swap;

  assign issue_any   = go && old_vld;
  assign pair_window = issue_any && yng_vld && !hazard &&
                       !cls_solo(old_cls) && !cls_solo(yng_cls);
  assign pair_plain  = pair_window && !cls_x_only(yng_cls);

  generate
    if (SWAP_EN) begin : g_swap
      assign pair_swap = pair_window && cls_x_only(yng_cls) &&
                         (old_cls == CLS_SIMPLE);
    end else begin : g_noswap
      assign pair_swap = 1'b0;
    end
  endgenerate

  always_comb begin
    if (!issue_any)     plan = PLAN_NONE;
    else if (pair_plain) plan = PLAN_PAIR;
    else if (pair_swap)  plan = PLAN_SWAP;
    else                 plan = PLAN_SINGLE;
  end

  assert_swap_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (plan == PLAN_SWAP) |-> (SWAP_EN && old_cls == CLS_SIMPLE &&
                             cls_x_only(yng_cls) && !hazard));

  assert_pair_needs_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (plan_slots(plan) == 2'd2) |-> (old_vld && yng_vld));

endmodule

// File: rtl/steer_route.sv
module steer_route
  import steer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  plan_e              plan,
  input  logic [1:0]         old_cls,
  input  logic [DATA_W-1:0]  old_data,
  input  logic [1:0]         yng_cls,
  input  logic [DATA_W-1:0]  yng_data,
  output logic               x_vld,
  output logic [1:0]         x_cls,
  output logic [DATA_W-1:0]  x_data,
  output logic               y_vld,
  output logic [1:0]         y_cls,
  output logic [DATA_W-1:0]  y_data,
  output logic               y_older,
  output logic               take_old,
  output logic               take_yng
);

  always_comb begin
    x_vld    = 1'b0;
    x_cls    = '0;
    x_data   = '0;
    y_vld    = 1'b0;
    y_cls    = '0;
    y_data   = '0;
    y_older  = 1'b0;
    take_old = 1'b0;
    take_yng = 1'b0;
    case (plan)
      PLAN_SINGLE: begin
        x_vld = 1'b1; x_cls = old_cls; x_data = old_data;
        take_old = 1'b1;
      end
      PLAN_PAIR: begin
        x_vld = 1'b1; x_cls = old_cls; x_data = old_data;
        y_vld = 1'b1; y_cls = yng_cls; y_data = yng_data;
        take_old = 1'b1; take_yng = 1'b1;
      end
      PLAN_SWAP: begin
        x_vld = 1'b1; x_cls = yng_cls; x_data = yng_data;
        y_vld = 1'b1; y_cls = old_cls; y_data = old_data;
        y_older = 1'b1;
        take_old = 1'b1; take_yng = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/steer_dual_issue.sv
module steer_dual_issue
  import steer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit SWAP_EN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid_old,
  input  logic [1:0]        dec_cls_old,
  input  logic [DATA_W-1:0] dec_data_old,
  input  logic              dec_valid_yng,
  input  logic [1:0]        dec_cls_yng,
  input  logic [DATA_W-1:0] dec_data_yng,
  input  logic              pair_hazard,
  output logic              dec_take_old,
  output logic              dec_take_yng,
  output logic              xp_valid,
  output logic [1:0]        xp_cls,
  output logic [DATA_W-1:0] xp_data,
  input  logic              xp_ready,
  output logic              yp_valid,
  output logic [1:0]        yp_cls,
  output logic [DATA_W-1:0] yp_data,
  input  logic              yp_ready,
  output logic              yp_holds_older
);

  logic  pipes_go;
  plan_e issue_plan;

  assign pipes_go = xp_ready && yp_ready;

  steer_pair_rule #(.SWAP_EN(SWAP_EN)) rule_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .old_vld (dec_valid_old),
    .old_cls (dec_cls_old),
    .yng_vld (dec_valid_yng),
    .yng_cls (dec_cls_yng),
    .hazard  (pair_hazard),
    .go      (pipes_go),
    .plan    (issue_plan)
  );

  steer_route #(.DATA_W(DATA_W)) route_i (
    .plan     (issue_plan),
    .old_cls  (dec_cls_old),
    .old_data (dec_data_old),
    .yng_cls  (dec_cls_yng),
    .yng_data (dec_data_yng),
    .x_vld    (xp_valid),
    .x_cls    (xp_cls),
    .x_data   (xp_data),
    .y_vld    (yp_valid),
    .y_cls    (yp_cls),
    .y_data   (yp_data),
    .y_older  (yp_holds_older),
    .take_old (dec_take_old),
    .take_yng (dec_take_yng)
  );

  assert_y_needs_x_R1: assert property (@(posedge clk) disable iff (!rst_n)
    yp_valid |-> xp_valid);

  assert_take_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_take_yng |-> dec_take_old);

  assert_take_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dec_take_old, dec_take_yng}) == $countones({xp_valid, yp_valid}));

  assert_y_no_xonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    yp_valid |-> !cls_x_only(yp_cls));

  assert_solo_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_valid && cls_solo(xp_cls)) |-> !yp_valid);

  assert_y_no_solo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    yp_valid |-> !cls_solo(yp_cls));

  assert_hazard_no_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hazard |-> !yp_valid);

  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(xp_ready && yp_ready) |-> !(xp_valid || yp_valid || dec_take_old || dec_take_yng));

  assert_order_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    yp_holds_older |-> (SWAP_EN && yp_valid && yp_cls == CLS_SIMPLE && cls_x_only(xp_cls)));

  assert_lone_young_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_old |-> !xp_valid);

endmodule

// File: tb/steer_dual_issue_tb.sv
module steer_dual_issue_tb_top;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         v0 = 0, v1 = 0, hz = 0, xr = 0, yr = 0;
  logic [1:0]   c0 = 0, c1 = 0;
  logic [W-1:0] d0 = 0, d1 = 0;

  logic         a_to, a_ty, a_xv, a_yv, a_ord;
  logic [1:0]   a_xc, a_yc;
  logic [W-1:0] a_xd, a_yd;
  logic         b_to, b_ty, b_xv, b_yv, b_ord;
  logic [1:0]   b_xc, b_yc;
  logic [W-1:0] b_xd, b_yd;

  steer_dual_issue #(.DATA_W(W), .SWAP_EN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid_old(v0), .dec_cls_old(c0), .dec_data_old(d0),
    .dec_valid_yng(v1), .dec_cls_yng(c1), .dec_data_yng(d1),
    .pair_hazard(hz), .dec_take_old(a_to), .dec_take_yng(a_ty),
    .xp_valid(a_xv), .xp_cls(a_xc), .xp_data(a_xd), .xp_ready(xr),
    .yp_valid(a_yv), .yp_cls(a_yc), .yp_data(a_yd), .yp_ready(yr),
    .yp_holds_older(a_ord));

  steer_dual_issue #(.DATA_W(W), .SWAP_EN(1'b1)) dut_swap_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid_old(v0), .dec_cls_old(c0), .dec_data_old(d0),
    .dec_valid_yng(v1), .dec_cls_yng(c1), .dec_data_yng(d1),
    .pair_hazard(hz), .dec_take_old(b_to), .dec_take_yng(b_ty),
    .xp_valid(b_xv), .xp_cls(b_xc), .xp_data(b_xd), .xp_ready(xr),
    .yp_valid(b_yv), .yp_cls(b_yc), .yp_data(b_yd), .yp_ready(yr),
    .yp_holds_older(b_ord));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Packed result: take_old, take_yng, xv, xcls, xdata, yv, ycls, ydata, order bit.
  function automatic logic [24:0] expect_vec(input bit swap);
    logic to = 0, ty = 0, xv = 0, yv = 0, ord = 0;
    logic [1:0] xc = 0, yc = 0;
    logic [W-1:0] xd = 0, yd = 0;
    if (xr && yr && v0) begin
      xv = 1; xc = c0; xd = d0; to = 1;
      if (v1 && !hz && c0 != 2'd3) begin
        case (c1)
          2'd0: begin yv = 1; yc = c1; yd = d1; ty = 1; end
          2'd1, 2'd2: if (swap && c0 == 2'd0) begin
            xc = c1; xd = d1; yv = 1; yc = c0; yd = d0; ord = 1; ty = 1;
          end
          default: ;
        endcase
      end
    end
    return {to, ty, xv, xc, xd, yv, yc, yd, ord};
  endfunction

  function automatic string req_tag(input bit swap);
    if (!(xr && yr)) return "R8";
    if (!v0)         return "R11";
    if (c0 == 2'd3)  return "R4";
    if (hz)          return "R7";
    if (c1 == 2'd3)  return "R6";
    if (v1 && (c1 == 2'd1 || c1 == 2'd2)) return swap ? "R10" : "R5";
    if (v1 && (c0 == 2'd1 || c0 == 2'd2)) return "R3";
    return "R2";
  endfunction

  task automatic compare(input string tag, input logic [24:0] act, input logic [24:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h (v0=%0d v1=%0d c0=%0d c1=%0d hz=%0d xr=%0d yr=%0d)",
               tag, act, exp, v0, v1, c0, c1, hz, xr, yr);
    end
  endtask

  initial begin
    // Reset state, idle inputs: every slot idle, nothing taken (R1).
    repeat (2) @(negedge clk);
    #2;
    compare("R1", {a_to, a_ty, a_xv, a_xc, a_xd, a_yv, a_yc, a_yd, a_ord}, '0);
    compare("R1", {b_to, b_ty, b_xv, b_xc, b_xd, b_yv, b_yc, b_yd, b_ord}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // Full sweep; payload (R12) and order bit (R9) are part of every compare.
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      v0 = i[0]; v1 = i[1]; c0 = i[3:2]; c1 = i[5:4];
      hz = i[6]; xr = i[7]; yr = i[8];
      d0 = i[7:0] ^ 8'h5A;
      d1 = ~i[7:0];
      #2;
      compare(req_tag(1'b0), {a_to, a_ty, a_xv, a_xc, a_xd, a_yv, a_yc, a_yd, a_ord},
              expect_vec(1'b0));
      compare(req_tag(1'b1), {b_to, b_ty, b_xv, b_xc, b_xd, b_yv, b_yc, b_yd, b_ord},
              expect_vec(1'b1));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule